// File: doc/BRIEF.md
# Boot PROM Phantom Overlay

This block places a 32-byte boot PROM over the lowest addresses of a system with an 8-bit data bus and a 16-bit address bus. After reset, with the enable strap tied high, every read from addresses 0x0000 to 0x001F is answered from the PROM. During those reads the block raises a phantom signal, and the system RAM keeps its output drivers off. Writes are never taken by the overlay, so code in the PROM can fill RAM underneath the PROM window while the PROM is still being read.

The overlay switches itself off on the first read whose address bit 5 is set, which is normally the jump out of the boot code. That read is served by RAM, and the overlay stays off until the next reset. A read that the PROM does not serve returns the RAM's data when the RAM acknowledges it, and 0xFF when no RAM responds. The PROM image is computed in the RTL, so no file is loaded.

Top module: `boot_overlay`

## Requirements
- R1: If the strap is high during reset, the overlay is active after reset, and a read at 0x0000 returns PROM byte 0 with phantom high.
- R2: If the strap is low during reset, the overlay is inactive after reset, and reads in 0x0000–0x001F return RAM data with phantom low.
- R3: While the overlay is active, a read whose address bits 15..5 are all zero returns, in the same cycle, the PROM byte indexed by address bits 4..0, with phantom and rd_valid high. PROM byte i equals ((i*29+7) mod 256) XOR 0x96.
- R4: A write (wr high, rd low) never raises phantom and never changes the overlay state, at any address, including addresses with bit 5 set.
- R5: While the overlay is active, a read with address bit 5 set is served by RAM with phantom low, and the overlay is inactive from the next clock edge on.
- R6: A read outside the window with address bit 5 clear, for example 0x0040 or 0x0100, leaves the overlay active.
- R7: Once inactive, the overlay stays inactive until the next reset, whatever the reads and writes.
- R8: A read that the PROM does not serve returns ram_rdata when ram_ack is high, and 0xFF when ram_ack is low.
- R9: While rd is low, phantom and rd_valid are low and rd_data is 0xFF. While rd is high, rd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_strap | input | 1 | Overlay enable strap, sampled during reset |
| addr | input | 16 | Bus address |
| rd | input | 1 | Memory read strobe |
| wr | input | 1 | Memory write strobe |
| ram_ack | input | 1 | RAM responded to the current read |
| ram_rdata | input | 8 | RAM read data |
| rd_data | output | 8 | Read data returned to the bus |
| rd_valid | output | 1 | Read data valid |
| phantom | output | 1 | Tells RAM to stay silent for this read |

## Verification
The hardest case to reach from the ports is a set of accesses that lie close to the disable condition but must not trigger it. These are reads outside the window with bit 5 clear, and writes with bit 5 set. Their only effect is on the internal active flag, which the ports do not show. The stimulus therefore follows each such access with a window read, and the source of that read's data (PROM or RAM) shows whether the flag survived. The read that disables the overlay is also checked twice: once in its own cycle, where RAM must serve it, and again on the next access.

// File: rtl/boot_overlay_pkg.sv
package boot_overlay_pkg;

    localparam int ADDR_W_DEF   = 16;
    localparam int DATA_W_DEF   = 8;
    localparam int WIN_BITS_DEF = 5;

    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_PROM = 2'd1,
        SRC_RAM  = 2'd2,
        SRC_OPEN = 2'd3
    } rd_src_e;

    function automatic logic [7:0] prom_byte(input int unsigned idx);
        int unsigned v;
        v = (idx * 29 + 7) % 256;
        return 8'(v) ^ 8'h96;
    endfunction

endpackage

// File: rtl/overlay_rom.sv
module overlay_rom
    import boot_overlay_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int WIN_BITS = WIN_BITS_DEF
) (
    input  logic [WIN_BITS-1:0] idx,
    output logic [DATA_W-1:0]   dout
);
    localparam int DEPTH = 1 << WIN_BITS;

    logic [DATA_W-1:0] image [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_img
        assign image[g] = DATA_W'(prom_byte(g));
    end

    assign dout = image[idx];
endmodule

// File: rtl/overlay_state.sv
module overlay_state (
    input  logic clk,
    input  logic rst,
    input  logic en_strap,
    input  logic rd,
    input  logic kill_bit,
    output logic active
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst)
            active_q <= en_strap;
        else if (active_q && rd && kill_bit)
            active_q <= 1'b0;
    end

    assign active = active_q;

    // R1 / R2: the flag follows the strap at reset
    assert_reset_arm_R1: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (active_q == $past(en_strap)));

    // R5: a read with the kill bit set turns the overlay off
    assert_kill_read_R5: assert property (@(posedge clk) disable iff (rst)
        (active_q && rd && kill_bit) |=> !active_q);

    // R7: sticky off
    assert_sticky_off_R7: assert property (@(posedge clk) disable iff (rst)
        !active_q |=> !active_q);

    // R6: any other access keeps the overlay on
    assert_keep_on_R6: assert property (@(posedge clk) disable iff (rst)
        (active_q && !(rd && kill_bit)) |=> active_q);
endmodule

// File: rtl/overlay_mux.sv
module overlay_mux
    import boot_overlay_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              rd,
    input  logic              prom_serve,
    input  logic              ram_ack,
    input  logic [DATA_W-1:0] prom_data,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_src_e src;

    always_comb begin
        if (!rd)
            src = SRC_IDLE;
        else if (prom_serve)
            src = SRC_PROM;
        else if (ram_ack)
            src = SRC_RAM;
        else
            src = SRC_OPEN;
    end

    always_comb begin
        unique case (src)
            SRC_PROM: rd_data = prom_data;
            SRC_RAM:  rd_data = ram_rdata;
            default:  rd_data = '1;
        endcase
    end

    assign rd_valid = (src != SRC_IDLE);
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay
    import boot_overlay_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DATA_W   = DATA_W_DEF,
    parameter int WIN_BITS = WIN_BITS_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_strap,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              ram_ack,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              phantom
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic              active;
    logic              in_window;
    logic              prom_serve;
    logic [DATA_W-1:0] prom_data;

    assign in_window  = (addr[ADDR_W-1:WIN_BITS] == HI_W'(0));
    assign prom_serve = active && rd && in_window;
    assign phantom    = prom_serve;

    overlay_state u_state (
        .clk      (clk),
        .rst      (rst),
        .en_strap (en_strap),
        .rd       (rd),
        .kill_bit (addr[WIN_BITS]),
        .active   (active)
    );

    overlay_rom #(.DATA_W(DATA_W), .WIN_BITS(WIN_BITS)) u_rom (
        .idx  (addr[WIN_BITS-1:0]),
        .dout (prom_data)
    );

    overlay_mux #(.DATA_W(DATA_W)) u_mux (
        .rd         (rd),
        .prom_serve (prom_serve),
        .ram_ack    (ram_ack),
        .prom_data  (prom_data),
        .ram_rdata  (ram_rdata),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // R4: writes never claim the bus
    assert_write_no_phantom_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && !rd) |-> !phantom);

    // R9: idle bus is quiet
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (!phantom && !rd_valid));

    // R2 / R7: an inactive overlay never asserts phantom
    assert_off_no_phantom_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> !phantom);
endmodule

// File: tb/boot_overlay_test.sv
module boot_overlay_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_strap = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic        ram_ack = 1'b0;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        phantom;

    int n_tests = 0;
    int n_fail  = 0;
    bit model_active = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] data;
        logic       valid;
        logic       ph;
        string      tag;
    } exp_t;

    exp_t sb[$];

    boot_overlay uut (
        .clk(clk), .rst(rst), .en_strap(en_strap), .addr(addr),
        .rd(rd), .wr(wr), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .phantom(phantom)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_prom(input int i);
        return 8'(((i * 29) + 7) & 255) ^ 8'd150;
    endfunction

    function automatic logic [7:0] ram_pattern(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    task automatic access(input bit r, input bit w, input logic [15:0] a,
                          input bit ack, input string tag);
        exp_t e;
        @(negedge clk);
        rd = r; wr = w; addr = a; ram_ack = ack; ram_rdata = ram_pattern(a);
        e.tag = tag;
        if (!r) begin
            e.data = 8'hFF; e.valid = 1'b0; e.ph = 1'b0;
        end else if (model_active && a[15:5] == 11'd0) begin
            e.data = exp_prom(int'(a[4:0])); e.valid = 1'b1; e.ph = 1'b1;
        end else begin
            e.data = ack ? ram_pattern(a) : 8'hFF; e.valid = 1'b1; e.ph = 1'b0;
        end
        sb.push_back(e);
        if (r && a[5]) model_active = 1'b0;
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst = 1'b1; en_strap = strap; rd = 0; wr = 0; ram_ack = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0; en_strap = ~strap;
        model_active = strap;
        access(0, 0, 16'h0000, 0, "R9 idle after reset");
    endtask

    // monitor: compares each cycle's outputs against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_tests++;
                if (rd_data !== e.data || rd_valid !== e.valid || phantom !== e.ph) begin
                    n_fail++;
                    $display("FAIL %s: got data=%02h valid=%0b ph=%0b exp data=%02h valid=%0b ph=%0b",
                             e.tag, rd_data, rd_valid, phantom, e.data, e.valid, e.ph);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        access(1, 0, 16'h0000, 1, "R1 prom byte 0 after strap reset");
        access(1, 0, 16'h001F, 1, "R3 top of window");
        access(1, 0, 16'h0007, 0, "R3 mid window");
        access(0, 1, 16'h0003, 1, "R4 write in window");
        access(0, 1, 16'h0020, 1, "R4 write with bit5");
        access(1, 0, 16'h0002, 1, "R4 still active after write");
        access(1, 0, 16'h0100, 0, "R8 open bus read");
        access(1, 0, 16'h0040, 1, "R6 bit5 clear outside window");
        access(1, 0, 16'h0005, 1, "R6 still active");
        access(1, 0, 16'h8010, 1, "R6 high address, bit5 clear");
        access(1, 0, 16'h001E, 1, "R6 still active again");
        access(0, 0, 16'h0004, 1, "R9 idle");
        access(1, 0, 16'h0020, 1, "R5 kill read served by RAM");
        access(1, 0, 16'h0000, 1, "R5 window now RAM");
        access(1, 0, 16'h0001, 0, "R8 window read, no RAM");
        access(0, 1, 16'h0000, 1, "R7 write after off");
        access(1, 0, 16'h0010, 1, "R7 stays off");
        do_reset(1'b0);
        access(1, 0, 16'h0000, 1, "R2 strap low window RAM");
        access(1, 0, 16'h001F, 0, "R2 strap low open bus");
        do_reset(1'b1);
        access(1, 0, 16'h0001, 1, "R1 rearm after reset");
        access(1, 0, 16'hFFFF, 0, "R5 kill at top of map");
        access(1, 0, 16'h0001, 1, "R7 off after second kill");
        for (int i = 0; i < 4; i++) access(1, 0, 16'(i * 7), 1, "R7 sweep off");
        do_reset(1'b1);
        for (int i = 0; i < 32; i++) access(1, 0, 16'(i), 0, "R3 full PROM sweep");
        access(0, 0, 16'h0000, 0, "R9 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule